// File: doc/BRIEF.md
# Normalizing Barrel Shifter with Exponent Detect

This unit is the shift stage of a 16-bit fixed-point signal processing datapath. It takes a 16-bit operand and places it in the upper or the lower half of a 32-bit field. It then moves the field left or right by a signed count, with either zero fill or sign fill. The result lands in a 32-bit result register. A single-cycle operation can either replace that register or be OR-merged into it, so two 16-bit halves can be built into one 32-bit word over two operations.

The unit also measures how many redundant sign bits an operand carries. This is its exponent. The exponent drives a normalize operation, which shifts the operand left until its leading significant bit sits just below the sign bit. A denormalize operation shifts arithmetically right by a given exponent. For block floating point, a block-exponent register keeps the smallest exponent seen across a run of words. That value gives the one shift that is safe for the whole block. The register is set back to its maximum by a dedicated operation.

All operations complete in one clock: inputs are sampled on an edge where `op_valid` is high, and the registered outputs show the new values after that edge. Operation codes on `op_code`: 0 logical shift, 1 arithmetic shift, 2 normalize, 3 denormalize, 4 derive exponent, 5 block-exponent update, 6 block-exponent restart, 7 no operation.

Top module: `shf_norm_unit`

## Requirements
- R1: After reset (rst_n low), `result` is 0, `exp_out` is 0 and `blk_exp` is DW-1 (15).
- R2: Code 0 (logical shift) places `din` in the top half when `place_hi`=1, or zero-extended in the bottom half when `place_hi`=0. A non-negative `shamt` then shifts left with zero fill, and a negative `shamt` shifts right by its magnitude with zero fill. A magnitude of 32 or more gives 0.
- R3: Code 1 (arithmetic shift) uses sign extension for bottom-half placement. A negative `shamt` shifts right with copies of bit 31, and a magnitude of 32 or more in that direction gives 32 copies of bit 31. Left shifts behave as in R2.
- R4: Code 2 (normalize) places `din` as in R3 and shifts it left by the exponent of `din` (see R5). With top-half placement, replace mode, and `din` neither all zeros nor all ones, bits 31 and 30 of the result differ.
- R5: Code 4 loads `exp_out` with the number of bits below bit 15 of `din` that equal bit 15, counted downward until the first bit that differs. The value is 0 to 15, and 0x0000 and 0xFFFF both give 15. `result` and `blk_exp` do not change.
- R6: For codes 0 to 3, `merge`=0 writes the shifted field into `result`, and `merge`=1 writes the bitwise OR of the shifted field and the previous `result`.
- R7: Code 3 (denormalize) places `din` as in R3 and shifts it arithmetically right by `shamt`. A negative `shamt` shifts left by its magnitude. Saturation is as in R2 and R3.
- R8: Code 5 loads `exp_out` with the exponent of `din` and loads `blk_exp` with the smaller of itself and that exponent. Code 6 sets `blk_exp` to 15. No other code changes `blk_exp`, and codes 0 to 3 leave `exp_out` unchanged.
- R9: With `op_valid`=0, or with code 7, all three outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Perform `op_code` on this edge |
| op_code | input | 3 | Operation select (codes listed above) |
| din | input | 16 | Operand |
| shamt | input | 8 | Signed shift count, two's complement |
| place_hi | input | 1 | 1: operand in upper half, 0: lower half |
| merge | input | 1 | 1: OR into result, 0: replace result |
| result | output | 32 | Shifted result register |
| exp_out | output | 8 | Last derived exponent |
| blk_exp | output | 8 | Block exponent (minimum since restart) |

## Verification
The bench builds the unit with its default parameters: a 16-bit operand, a 32-bit field and an 8-bit count. An 8-bit count reaches magnitudes up to 128, far past the field width. Random counts therefore reach the all-zero and all-sign saturation cases on both sides, as well as the count of -128, whose negation overflows eight bits. With a 16-bit operand, all sixteen exponent values can be reached, from 0 through the all-zero and all-one cases. The bench also runs block-exponent sequences long enough to see the minimum fall, hold and restart.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
package shf_pkg;
  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXP    = 3'd4,
    OP_BEXP   = 3'd5,
    OP_BCLR   = 3'd6,
    OP_NOP    = 3'd7
  } shf_op_e;

  function automatic logic is_shift_op(input logic [2:0] code);
    return (code == OP_LSH) || (code == OP_ASH) ||
           (code == OP_NORM) || (code == OP_DENORM);
  endfunction
endpackage

// File: rtl/shf_place.sv
`timescale 1ns/1ps
module shf_place #(
  parameter int DW = 16,
  parameter int RW = 32
) (
  input  logic [DW-1:0] din,
  input  logic          hi,
  input  logic          sext,
  output logic [RW-1:0] field
);
  localparam int PAD = RW - DW;

  always_comb begin
    if (hi) field = {din, {PAD{1'b0}}};
    else    field = {{PAD{sext & din[DW-1]}}, din};
  end
endmodule

// File: rtl/shf_expdet.sv
`timescale 1ns/1ps
module shf_expdet #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic [DW-1:0] din,
  output logic [CW-1:0] exp_val
);
  function automatic logic [CW-1:0] sign_run(input logic [DW-1:0] v);
    logic          run;
    logic [CW-1:0] n;
    run = 1'b1;
    n   = '0;
    for (int i = DW - 2; i >= 0; i--) begin
      if (run && (v[i] == v[DW-1])) n = n + CW'(1);
      else                          run = 1'b0;
    end
    return n;
  endfunction

  assign exp_val = sign_run(din);
endmodule

// File: rtl/shf_core.sv
`timescale 1ns/1ps
module shf_core #(
  parameter int RW   = 32,
  parameter int CNTW = 9
) (
  input  logic [RW-1:0]   field,
  input  logic [CNTW-1:0] cnt,
  input  logic            arith,
  output logic [RW-1:0]   shifted
);
  localparam int STG = $clog2(RW);

  logic            go_right;
  logic [CNTW-1:0] mag;
  logic            too_far;
  logic [RW-1:0]   lft [0:STG];
  logic [RW-1:0]   rgt [0:STG];

  assign go_right = cnt[CNTW-1];
  assign mag      = go_right ? (CNTW'(0) - cnt) : cnt;
  assign too_far  = (mag >= CNTW'(RW));

  assign lft[0] = field;
  assign rgt[0] = field;

  for (genvar s = 0; s < STG; s++) begin : g_stage
    localparam int AMT = 1 << s;
    assign lft[s+1] = mag[s] ? (lft[s] << AMT) : lft[s];
    assign rgt[s+1] = !mag[s] ? rgt[s] :
                      arith   ? RW'($signed(rgt[s]) >>> AMT) : (rgt[s] >> AMT);
  end

  always_comb begin
    if (too_far)       shifted = (go_right && arith) ? {RW{field[RW-1]}} : '0;
    else if (go_right) shifted = rgt[STG];
    else               shifted = lft[STG];
  end
endmodule

// File: rtl/shf_norm_unit.sv
`timescale 1ns/1ps
module shf_norm_unit #(
  parameter int DW = 16,
  parameter int RW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] shamt,
  input  logic          place_hi,
  input  logic          merge,
  output logic [RW-1:0] result,
  output logic [CW-1:0] exp_out,
  output logic [CW-1:0] blk_exp
);
  import shf_pkg::*;

  localparam int            CNTW    = CW + 1;
  localparam logic [CW-1:0] EXP_MAX = CW'(DW - 1);

  logic            shift_en;
  logic            exp_load;
  logic            blk_upd;
  logic            blk_clr;
  logic            use_arith;
  logic [CW-1:0]   exp_now;
  logic [CW-1:0]   blk_next;
  logic [CNTW-1:0] cnt_ext;
  logic [CNTW-1:0] cnt_sel;
  logic [RW-1:0]   field;
  logic [RW-1:0]   shifted;

  assign shift_en  = op_valid && is_shift_op(op_code);
  assign blk_upd   = op_valid && (op_code == OP_BEXP);
  assign blk_clr   = op_valid && (op_code == OP_BCLR);
  assign exp_load  = (op_valid && (op_code == OP_EXP)) || blk_upd;
  assign use_arith = (op_code != OP_LSH);
  assign cnt_ext   = {shamt[CW-1], shamt};

  always_comb begin
    case (op_code)
      OP_NORM:   cnt_sel = CNTW'(exp_now);
      OP_DENORM: cnt_sel = CNTW'(0) - cnt_ext;
      default:   cnt_sel = cnt_ext;
    endcase
  end

  shf_place #(.DW(DW), .RW(RW)) u_place (
    .din(din), .hi(place_hi), .sext(use_arith), .field(field)
  );

  shf_expdet #(.DW(DW), .CW(CW)) u_expdet (
    .din(din), .exp_val(exp_now)
  );

  shf_core #(.RW(RW), .CNTW(CNTW)) u_core (
    .field(field), .cnt(cnt_sel), .arith(use_arith), .shifted(shifted)
  );

  assign blk_next = (exp_now < blk_exp) ? exp_now : blk_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      exp_out <= '0;
      blk_exp <= EXP_MAX;
    end else begin
      if (shift_en) result <= merge ? (result | shifted) : shifted;
      if (exp_load) exp_out <= exp_now;
      if (blk_clr)      blk_exp <= EXP_MAX;
      else if (blk_upd) blk_exp <= blk_next;
    end
  end

  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    exp_out <= EXP_MAX); // R5

  AST_BLK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_clr |=> blk_exp <= $past(blk_exp)); // R8

  AST_BLK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    blk_clr |=> blk_exp == EXP_MAX); // R8

  AST_MERGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && merge) |=> ((result & $past(result)) == $past(result))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(result) && $stable(exp_out) && $stable(blk_exp))); // R9

  AST_NON_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(result)); // R5

  AST_NORM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_NORM && place_hi && !merge &&
     din != {DW{1'b0}} && din != {DW{1'b1}})
    |=> result[RW-1] != result[RW-2]); // R4
endmodule

// File: tb/tb_shf_norm_unit.sv
`timescale 1ns/1ps
module tb_shf_norm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd7;
  logic [15:0] din = '0;
  logic [7:0]  shamt = '0;
  logic        place_hi = 1'b0;
  logic        merge = 1'b0;
  logic [31:0] result;
  logic [7:0]  exp_out;
  logic [7:0]  blk_exp;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_res;
  logic [7:0]  m_exp;
  logic [7:0]  m_blk;

  always #2 clk = ~clk;

  shf_norm_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .din(din), .shamt(shamt), .place_hi(place_hi), .merge(merge),
    .result(result), .exp_out(exp_out), .blk_exp(blk_exp)
  );

  function automatic int ref_exp(input logic [15:0] v);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (v[i] != v[15]) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [31:0] ref_shift(input logic [31:0] f, input int c, input bit ar);
    int m;
    if (c >= 0) return (c >= 32) ? 32'h0 : (f << c);
    m = -c;
    if (m >= 32) return ar ? {32{f[31]}} : 32'h0;
    if (ar) return 32'($signed(f) >>> m);
    return f >> m;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_op(input bit v, input int op, input logic [15:0] d,
                       input logic [7:0] sh, input bit hi, input bit mg, input string tag);
    logic [31:0] f;
    bit          ar;
    int          c;
    int          e;
    @(negedge clk);
    op_valid = v; op_code = 3'(op); din = d; shamt = sh; place_hi = hi; merge = mg;
    e  = ref_exp(d);
    ar = (op != 0);
    f  = hi ? {d, 16'h0} : (ar ? {{16{d[15]}}, d} : {16'h0, d});
    c  = (op == 2) ? e : (op == 3) ? -int'($signed(sh)) : int'($signed(sh));
    if (v) begin
      if (op <= 3) m_res = mg ? (m_res | ref_shift(f, c, ar)) : ref_shift(f, c, ar);
      if (op == 4 || op == 5) m_exp = 8'(e);
      if (op == 5 && e < int'(m_blk)) m_blk = 8'(e);
      if (op == 6) m_blk = 8'd15;
    end
    @(negedge clk);
    op_valid = 1'b0;
    check({tag, " result"}, result, m_res);
    check({tag, " exp_out"}, 32'(exp_out), 32'(m_exp));
    check({tag, " blk_exp"}, 32'(blk_exp), 32'(m_blk));
  endtask

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    process::self().srandom(32'd5150);
    m_res = '0; m_exp = '0; m_blk = 8'd15;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 result", result, 32'h0);
    check("R1 exp_out", 32'(exp_out), 32'h0);
    check("R1 blk_exp", 32'(blk_exp), 32'd15);
    rst_n = 1'b1;

    // R2 logical shifts and saturation
    do_op(1, 0, 16'h8421, 8'd0,    1, 0, "R2 zero");
    do_op(1, 0, 16'h8421, 8'd5,    0, 0, "R2 left");
    do_op(1, 0, 16'h8421, -8'sd3,  1, 0, "R2 right");
    do_op(1, 0, 16'hFFFF, -8'sd31, 1, 0, "R2 right31");
    do_op(1, 0, 16'hFFFF, 8'd32,   0, 0, "R2 left32");
    do_op(1, 0, 16'hFFFF, 8'h80,   1, 0, "R2 min");
    // R3 arithmetic shifts
    do_op(1, 1, 16'h9000, -8'sd4,  0, 0, "R3 sext");
    do_op(1, 1, 16'h9000, -8'sd40, 1, 0, "R3 sat");
    do_op(1, 1, 16'h7000, -8'sd40, 1, 0, "R3 satpos");
    do_op(1, 1, 16'h8001, 8'd127,  0, 0, "R3 left");
    // R4 normalize
    do_op(1, 2, 16'h0001, 8'd0, 1, 0, "R4 one");
    do_op(1, 2, 16'hFFFE, 8'd0, 1, 0, "R4 neg");
    do_op(1, 2, 16'h0000, 8'd0, 1, 0, "R4 zero");
    do_op(1, 2, 16'h0123, 8'd0, 0, 0, "R4 low");
    // R5 exponent
    do_op(1, 4, 16'h4000, 8'd9, 1, 0, "R5 e0");
    do_op(1, 4, 16'hC000, 8'd9, 1, 0, "R5 e1");
    do_op(1, 4, 16'hFFFF, 8'd9, 1, 0, "R5 ones");
    do_op(1, 4, 16'h0001, 8'd9, 1, 0, "R5 e14");
    // R6 merge
    do_op(1, 0, 16'h00F0, 8'd0,    0, 0, "R6 base");
    do_op(1, 0, 16'h0F00, 8'd0,    1, 1, "R6 or");
    do_op(1, 1, 16'h0003, 8'd0,    0, 0, "R6 replace");
    // R7 denormalize
    do_op(1, 3, 16'h8000, 8'd3,    1, 0, "R7 right");
    do_op(1, 3, 16'h0040, -8'sd2,  0, 0, "R7 left");
    do_op(1, 3, 16'h8000, 8'h80,   1, 0, "R7 min");
    do_op(1, 3, 16'h8000, 8'd50,   1, 0, "R7 sat");
    // R8 block exponent
    do_op(1, 6, 16'h0, 8'd0,   1, 0, "R8 clr");
    do_op(1, 5, 16'h0F00, 8'd0, 1, 0, "R8 upd");
    do_op(1, 5, 16'h00F0, 8'd0, 1, 0, "R8 keep");
    do_op(1, 5, 16'hE000, 8'd0, 1, 0, "R8 lower");
    do_op(1, 4, 16'h0000, 8'd0, 1, 0, "R8 expop");
    do_op(1, 6, 16'h0, 8'd0,   1, 0, "R8 restart");
    // R9 idle and no-op
    do_op(0, 0, 16'h1234, 8'd2, 0, 0, "R9 idle");
    do_op(0, 6, 16'h1234, 8'd2, 0, 0, "R9 idleclr");
    do_op(1, 7, 16'h1234, 8'd2, 0, 0, "R9 nop");

    for (int k = 0; k < 2000; k++) begin
      int op = int'($urandom_range(0, 7));
      logic [15:0] d;
      logic [7:0]  s;
      case ($urandom_range(0, 3))
        0: d = 16'($urandom) >> $urandom_range(0, 15);
        1: d = ~(16'($urandom) >> $urandom_range(0, 15));
        default: d = 16'($urandom);
      endcase
      s = ($urandom_range(0, 1) != 0) ? 8'($urandom) : 8'($signed(6'($urandom)));
      if (op == 6 && $urandom_range(0, 3) != 0) op = 5;
      do_op($urandom_range(0, 9) != 0, op, d, s, 1'($urandom), 1'($urandom),
            "R2-R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule